// File: doc/BRIEF.md
# DMA Bus Handover Controller

This block sits on the permanent bus master and decides when a temporary master, such as a DMA engine or a second processor, may take over the bus. Up to four temporary masters signal their wish with active-low request lines. Together with these, an active-low hold request asks the permanent master to give up the bus. A mask input lets the permanent master refuse new handovers.

Once a handover is pending, the controller tells the permanent master to stall, so that it starts no new bus cycle. It waits for a cycle boundary, where sync and both strobes are idle. It then floats the master's drivers in four separate groups: address, data-out, status and control. One clock later it raises hold-acknowledge and shows which requester won, with the lowest index taking priority. When hold is withdrawn, the drivers are restored one clock before hold-acknowledge drops, and the stall is then lifted. The memory write strobe keeps its driver in every state, so that one device in the system can go on generating it.

The per-line output enables are brought out as ports so that a testbench can watch each group. Electrical tristate timing is outside this block.

Top module: `bus_handover_ctrl`

## Requirements
- R1: After reset, stall_o=0, hold_ack_o=0, grant_o=0, and every output enable (address, data-out, status, control, memory write) is 1.
- R2: A handover is pending when hold_ni=0, hold_mask_i=0 and at least one req_ni bit is 0. From idle, a pending handover sets stall_o=1 at the next clock edge, with the enables still 1 and hold_ack_o still 0.
- R3: While stall_o=0 and hold_mask_i=1, no handover starts. Raising the mask while stalled and not yet floated returns the block to idle at the next edge. Raising the mask while granted has no effect.
- R4: The driver groups float (enable 0) only at an edge where sync_i, rd_strb_i and wr_strb_i were all 0. While any of them is 1, the block stays stalled with the enables at 1.
- R5: hold_ack_o rises exactly one clock after the groups float.
- R6: grant_o is one-hot while hold_ack_o=1. Bit i is set for the lowest index i whose req_ni[i] was 0 at the floating edge. grant_o is 0 whenever hold_ack_o=0.
- R7: The 24 address, 8 data-out, 7 status and 5 control enables always fall together and rise together.
- R8: mwrt_oe_o stays 1 in every state, including while the control group is floated.
- R9: When hold_ni goes to 1 while granted, the enables return to 1 at the next edge with hold_ack_o still 1. At the edge after that, hold_ack_o=0, grant_o=0 and stall_o=0.
- R10: If hold is released or all requests are withdrawn while stalled and not yet floated, the block returns to idle at the next edge without floating any group.
- R11: Once granted, changes on req_ni do not alter grant_o until the release completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_ni | input | 4 | Requests from temporary masters, active low, bit 0 highest priority |
| hold_ni | input | 1 | Hold request, active low |
| hold_mask_i | input | 1 | Blocks new handovers when 1 |
| sync_i | input | 1 | Bus cycle sync active |
| rd_strb_i | input | 1 | Read strobe active |
| wr_strb_i | input | 1 | Write strobe active |
| stall_o | output | 1 | Permanent master must not start a new cycle |
| hold_ack_o | output | 1 | Bus handed to a temporary master |
| grant_o | output | 4 | One-hot winning requester |
| addr_oe_o | output | 24 | Address driver enables |
| dout_oe_o | output | 8 | Data-out driver enables |
| stat_oe_o | output | 7 | Status driver enables |
| ctrl_oe_o | output | 5 | Control driver enables (sync, status-valid, read, write, hold-ack) |
| mwrt_oe_o | output | 1 | Memory write strobe driver enable |

## Verification
All outputs are decoded from one registered state, so every result is due at the first clock edge after the input that causes it. The only chain is float, then acknowledge, then release, then idle, with one edge between each step. The bench changes inputs 1 ns after a rising edge and samples 1 ns after the next rising edge, so each check looks at exactly one edge. It steps through the handover one edge at a time, checking stall, the enables, acknowledge and grant at each step. This is repeated for all fifteen non-empty request patterns, with the expected winner computed from the lowest zero bit. Busy-bus stretches and aborts in mid-handover are checked the same way.

// File: rtl/bho_pkg.sv
package bho_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_DRAIN   = 3'd1,
    ST_FLOAT   = 3'd2,
    ST_GRANT   = 3'd3,
    ST_RELEASE = 3'd4
  } hand_st_e;
endpackage

// File: rtl/bho_prio.sv
module bho_prio #(
  parameter int N = 4
) (
  input  logic [N-1:0] act_i,
  output logic [N-1:0] win_o,
  output logic         any_o
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  // lowest index wins
  for (genvar i = 0; i < N; i++) begin : g_chain
    assign win_o[i]    = act_i[i] & ~seen[i];
    assign seen[i+1]   = seen[i] | act_i[i];
  end

  assign any_o = seen[N];
endmodule

// File: rtl/bho_seq.sv
module bho_seq
  import bho_pkg::*;
#(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         pend_i,
  input  logic         hold_act_i,
  input  logic         quiet_i,
  input  logic [N-1:0] win_i,
  output logic         stall_o,
  output logic         dis_o,
  output logic         hold_ack_o,
  output logic [N-1:0] grant_o
);
  hand_st_e st_q, st_d;
  logic [N-1:0] win_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:    if (pend_i) st_d = ST_DRAIN;
      ST_DRAIN: begin
        if (!pend_i)      st_d = ST_IDLE;
        else if (quiet_i) st_d = ST_FLOAT;
      end
      ST_FLOAT:   st_d = ST_GRANT;
      ST_GRANT:   if (!hold_act_i) st_d = ST_RELEASE;
      ST_RELEASE: st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      win_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_DRAIN && st_d == ST_FLOAT) win_q <= win_i;
      else if (st_q == ST_RELEASE)              win_q <= '0;
    end
  end

  assign stall_o    = (st_q != ST_IDLE);
  assign dis_o      = (st_q == ST_FLOAT) || (st_q == ST_GRANT);
  assign hold_ack_o = (st_q == ST_GRANT) || (st_q == ST_RELEASE);
  assign grant_o    = win_q & {N{hold_ack_o}};

  AST_FLOAT_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dis_o) |-> $past(quiet_i)) else $error("float off boundary"); // R4
  AST_ACK_AFTER_FLOAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_ack_o) |-> $past(dis_o)) else $error("ack before float"); // R5
  AST_RESTORE_BEFORE_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dis_o) |-> hold_ack_o) else $error("ack dropped with float"); // R9
  AST_DROP_AFTER_RESTORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_ack_o) |-> $past(!dis_o)) else $error("ack dropped while floated"); // R9
endmodule

// File: rtl/bho_oe.sv
module bho_oe #(
  parameter int W = 8
) (
  input  logic         dis_i,
  output logic [W-1:0] oe_o
);
  assign oe_o = {W{~dis_i}};
endmodule

// File: rtl/bus_handover_ctrl.sv
module bus_handover_ctrl #(
  parameter int N_REQ  = 4,
  parameter int ADDR_W = 24,
  parameter int DOUT_W = 8,
  parameter int STAT_W = 7,
  parameter int CTRL_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_REQ-1:0]  req_ni,
  input  logic              hold_ni,
  input  logic              hold_mask_i,
  input  logic              sync_i,
  input  logic              rd_strb_i,
  input  logic              wr_strb_i,
  output logic              stall_o,
  output logic              hold_ack_o,
  output logic [N_REQ-1:0]  grant_o,
  output logic [ADDR_W-1:0] addr_oe_o,
  output logic [DOUT_W-1:0] dout_oe_o,
  output logic [STAT_W-1:0] stat_oe_o,
  output logic [CTRL_W-1:0] ctrl_oe_o,
  output logic              mwrt_oe_o
);
  logic [N_REQ-1:0] win;
  logic any_req, pend, quiet, dis;

  bho_prio #(.N(N_REQ)) u_prio (.act_i(~req_ni), .win_o(win), .any_o(any_req));

  assign pend  = !hold_ni && !hold_mask_i && any_req;
  assign quiet = !(sync_i || rd_strb_i || wr_strb_i);

  bho_seq #(.N(N_REQ)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .pend_i(pend), .hold_act_i(!hold_ni),
    .quiet_i(quiet), .win_i(win), .stall_o(stall_o), .dis_o(dis),
    .hold_ack_o(hold_ack_o), .grant_o(grant_o)
  );

  bho_oe #(.W(ADDR_W)) u_oe_addr (.dis_i(dis),  .oe_o(addr_oe_o));
  bho_oe #(.W(DOUT_W)) u_oe_dout (.dis_i(dis),  .oe_o(dout_oe_o));
  bho_oe #(.W(STAT_W)) u_oe_stat (.dis_i(dis),  .oe_o(stat_oe_o));
  bho_oe #(.W(CTRL_W)) u_oe_ctrl (.dis_i(dis),  .oe_o(ctrl_oe_o));
  // write strobe driver is never part of the control group
  bho_oe #(.W(1))      u_oe_mwrt (.dis_i(1'b0), .oe_o(mwrt_oe_o));

  AST_NO_START_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_o && hold_mask_i) |=> !stall_o) else $error("start while masked"); // R3
  AST_GRANT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_ack_o |-> $onehot(grant_o)) else $error("grant not one-hot"); // R6
  AST_GRANT_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_ack_o && $past(hold_ack_o)) |-> $stable(grant_o)) else $error("grant moved"); // R11
endmodule

// File: tb/tb_bus_handover_ctrl.sv
`timescale 1ns/1ps
module tb_bus_handover_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] req_n = 4'hF;
  logic hold_n = 1'b1, mask = 1'b0, sync = 1'b0, rd = 1'b0, wr = 1'b0;
  logic stall, ack, mwrt_oe;
  logic [3:0] grant;
  logic [23:0] addr_oe;
  logic [7:0] dout_oe;
  logic [6:0] stat_oe;
  logic [4:0] ctrl_oe;
  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bus_handover_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .req_ni(req_n), .hold_ni(hold_n),
    .hold_mask_i(mask), .sync_i(sync), .rd_strb_i(rd), .wr_strb_i(wr),
    .stall_o(stall), .hold_ack_o(ack), .grant_o(grant), .addr_oe_o(addr_oe),
    .dout_oe_o(dout_oe), .stat_oe_o(stat_oe), .ctrl_oe_o(ctrl_oe), .mwrt_oe_o(mwrt_oe)
  );

  // {stall, ack, grant[3:0], group code: 2=all on,1=all off,0=mixed, mwrt}
  function automatic logic [8:0] obs();
    logic [1:0] g;
    if (&addr_oe && &dout_oe && &stat_oe && &ctrl_oe) g = 2'd2;
    else if (!(|addr_oe) && !(|dout_oe) && !(|stat_oe) && !(|ctrl_oe)) g = 2'd1;
    else g = 2'd0;
    return {stall, ack, grant, g, mwrt_oe};
  endfunction

  function automatic logic [8:0] want(logic s, logic a, logic [3:0] gr, logic fl);
    return {s, a, gr, (fl ? 2'd1 : 2'd2), 1'b1};
  endfunction

  task automatic chk(string tag, logic [8:0] exp);
    logic [8:0] got = obs();
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b exp %b", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  function automatic logic [3:0] lowest(logic [3:0] act);
    for (int i = 0; i < 4; i++) if (act[i]) return 4'(1 << i);
    return 4'h0;
  endfunction

  // full handover with bus busy for 'busy' edges
  task automatic handover(logic [3:0] act, int busy);
    logic [3:0] g = lowest(act);
    req_n = ~act; hold_n = 1'b0; sync = (busy > 0);
    step(); chk("R2 stall on pend", want(1, 0, 0, 0));
    for (int b = 1; b < busy; b++) begin
      rd = b[0]; wr = ~b[0]; sync = 1'b0;
      step(); chk("R4 busy keeps driving", want(1, 0, 0, 0));
    end
    sync = 1'b0; rd = 1'b0; wr = 1'b0;
    step(); chk("R4 R7 R8 float at boundary", want(1, 0, 0, 1));
    req_n = 4'hF ^ 4'h1;   // change requests during grant
    mask = 1'b1;
    step(); chk("R5 R6 ack with winner", want(1, 1, g, 1));
    step(); chk("R11 R3 grant held", want(1, 1, g, 1));
    mask = 1'b0; hold_n = 1'b1; req_n = 4'hF;
    step(); chk("R9 restore before ack drop", want(1, 1, g, 0));
    step(); chk("R9 ack dropped", want(0, 0, 0, 0));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1; chk("R1 reset", want(0, 0, 0, 0));
    rst_n = 1'b1;
    step(); chk("R1 idle after reset", want(0, 0, 0, 0));

    // R2 only hold, no request: nothing
    hold_n = 1'b0; step(); chk("R2 hold alone", want(0, 0, 0, 0));
    hold_n = 1'b1; req_n = 4'h0; step(); chk("R2 requests alone", want(0, 0, 0, 0));
    req_n = 4'hF;

    // R3 masked: nothing starts
    mask = 1'b1; hold_n = 1'b0; req_n = 4'h5;
    for (int k = 0; k < 3; k++) begin step(); chk("R3 masked idle", want(0, 0, 0, 0)); end
    mask = 1'b0; hold_n = 1'b1; req_n = 4'hF; step();

    // R6 sweep of all request patterns and busy lengths
    for (int a = 1; a < 16; a++) handover(4'(a), a % 4);

    // R10 hold dropped while draining
    hold_n = 1'b0; req_n = 4'hB; sync = 1'b1;
    step(); chk("R2 drain", want(1, 0, 0, 0));
    hold_n = 1'b1;
    step(); chk("R10 hold drop aborts", want(0, 0, 0, 0));
    // R10 requests withdrawn while draining
    hold_n = 1'b0; step(); chk("R2 drain again", want(1, 0, 0, 0));
    req_n = 4'hF; step(); chk("R10 requests withdrawn", want(0, 0, 0, 0));
    // R3 mask while draining
    req_n = 4'h7; step(); chk("R2 drain third", want(1, 0, 0, 0));
    mask = 1'b1; step(); chk("R3 mask aborts drain", want(0, 0, 0, 0));
    mask = 1'b0; sync = 1'b0; hold_n = 1'b1; req_n = 4'hF; step();

    // back-to-back handovers with quiet bus
    handover(4'h8, 0);
    handover(4'hC, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got %0d cycles exp < 20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule